// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block collects one fast interrupt input, six external request lines and a parameterised set of on-chip peripheral lines, and turns them into two active-low requests for a processor core: a normal request and a fast request. Each source carries its own configuration word. The word holds an enable bit, a trigger mode (level or rising edge), a 3-bit priority and a 24-bit vector. All source inputs are taken through a two-stage synchroniser before use.

Software takes a normal interrupt by reading the vector register. The read returns the vector of the best pending source and acknowledges it: the source's level is pushed onto an 8-deep level stack, and an edge-mode pending bit is cleared. A write to the end-of-interrupt register pops the stack. A source requests service only when its priority is strictly above the level on top of the stack, so higher-priority sources can nest. When no source qualifies at the moment of the read, a programmable spurious vector is returned instead. In protect mode a read returns the same value with no side effect, and the acknowledge moves to a write of the vector register. This lets a debugger inspect the controller safely.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_no and fiq_no are high, every source configuration is zero (disabled), the spurious vector is zero, protect mode is off and the level stack is empty.
- R2: Source 0 is the fast line. fiq_no is low exactly while source 0 is both enabled and pending. Source 0 never drives irq_no. In edge mode its pending bit stays set until a write to address 0x25.
- R3: A source whose enable bit (bit 4 of its configuration word) is 0 never drives irq_no and is never returned by a vector read.
- R4: A vector read returns bits 31:8 of the winning source's configuration word in rdata_o[23:0]. The winner is the enabled pending source (1 and up) with the highest priority (bits 2:0, 7 highest). On equal priority the lowest source number wins.
- R5: irq_no is low only when a winner exists and either the stack is empty or the winner's priority is strictly greater than the level on top of the stack.
- R6: An acknowledge pushes the winner's priority onto the stack. A write to address 0x21 (end of interrupt) pops one level when the stack is not empty and is ignored when it is empty.
- R7: A vector read when irq_no would be high returns the spurious vector (address 0x22, bits 23:0) and changes no state.
- R8: In level mode (bit 3 = 0) a source is pending while its synchronised input is high. In edge mode (bit 3 = 1) a rising edge of the synchronised input sets a pending bit, which is cleared when that source is acknowledged.
- R9: With protect mode on (address 0x23, bit 0), a vector read returns the same value but acknowledges nothing. A write to the vector address (0x20) then performs the acknowledge.
- R10: A read of address 0x24 returns the pending bit of every source, unmasked, with bit s for source s. A read of address s below the source count returns that source's configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fiq_src_i | input | 1 | Fast interrupt line (source 0) |
| ext_irq_i | input | 6 | External request lines (sources 1 to 6) |
| per_irq_i | input | N_PER | Peripheral request lines (sources 7 and up) |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects on vector address) |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_no | output | 1 | Normal interrupt request, active low |
| fiq_no | output | 1 | Fast interrupt request, active low |

## Verification
The assertions assume that software honours the acknowledge and end-of-interrupt protocol. Every push must follow a request whose priority is above the stack top, so the stack can never exceed eight entries. The assertions also assume that read and write strobes are not raised together on the vector and end-of-interrupt addresses. The stimulus follows these rules: each bus access raises a single strobe for one cycle, and every end-of-interrupt write matches a vector read that returned a real vector. Source inputs are held for at least two clock cycles so that the synchroniser sees them.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W = 3;
  localparam int LEVELS = 8;
  localparam int VEC_W  = 24;
  localparam int ADDR_W = 6;
  localparam int N_EXT  = 6;

  localparam logic [ADDR_W-1:0] A_VEC  = 6'h20;
  localparam logic [ADDR_W-1:0] A_EOI  = 6'h21;
  localparam logic [ADDR_W-1:0] A_SPUR = 6'h22;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h23;
  localparam logic [ADDR_W-1:0] A_PEND = 6'h24;
  localparam logic [ADDR_W-1:0] A_FCLR = 6'h25;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic [2:0]        pad;
    logic              en;
    logic              edge_md;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/vic_src_front.sv
module vic_src_front #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  input  logic [N-1:0] edge_md_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic s1_q, s2_q, s3_q, pend_q, rise;
    assign rise = s2_q & ~s3_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0; pend_q <= 1'b0;
      end else begin
        s1_q <= in_i[s];
        s2_q <= s1_q;
        s3_q <= s2_q;
        // a fresh edge wins over a same-cycle clear
        if (rise)          pend_q <= 1'b1;
        else if (clr_i[s]) pend_q <= 1'b0;
      end
    end

    assign pend_o[s] = edge_md_i[s] ? pend_q : s2_q;

    a_r8_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_md_i[s] && rise) |=> pend_q);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N  = 16,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          valid_i,
  input  logic [N-1:0][PW-1:0]  prio_i,
  output logic                  any_o,
  output logic [IW-1:0]         idx_o,
  output logic [PW-1:0]         prio_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    // scan downward with >= so the lowest index wins ties
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i] && (!any_o || prio_i[i] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        prio_o = prio_i[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r4_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_o && valid_i[i]) |-> (prio_i[i] <= prio_o));
    a_r4_tie_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_o && valid_i[i] && prio_i[i] == prio_o) |-> (idx_o <= IW'(i)));
    a_r3_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_o && idx_o == IW'(i)) |-> valid_i[i]);
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int IW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] lvl_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic [PW-1:0] top_o,
  output logic [SW-1:0] depth_o
);
  logic [DEPTH-1:0][PW-1:0] lvl_q;
  logic [SW-1:0]            sp_q;
  logic [IW-1:0]            top_idx;

  assign top_idx = sp_q[IW-1:0] - IW'(1);
  assign empty_o = (sp_q == '0);
  assign top_o   = empty_o ? '0 : lvl_q[top_idx];
  assign depth_o = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      lvl_q <= '0;
    end else if (push_i && sp_q != SW'(DEPTH)) begin
      lvl_q[sp_q[IW-1:0]] <= lvl_i;
      sp_q <= sp_q + SW'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - SW'(1);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (sp_q != SW'(DEPTH)));
  a_r5_nest_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |=> (top_o > $past(top_o)));
  a_r6_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (sp_q == $past(sp_q) - SW'(1)));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int N_PER = 9,
  localparam int N_SRC = 1 + N_EXT + N_PER,
  localparam int IW    = $clog2(N_SRC),
  localparam int SW    = $clog2(LEVELS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fiq_src_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic [N_PER-1:0]  per_irq_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_no,
  output logic              fiq_no
);
  src_cfg_t [N_SRC-1:0]             cfg_q;
  logic [VEC_W-1:0]                 spur_q;
  logic                             prot_q;
  logic [N_SRC-1:0]                 en, edge_md, pend, valid, clr;
  logic [N_SRC-1:0][PRIO_W-1:0]     prio;
  logic                             any, req, empty, ack, pop;
  logic [IW-1:0]                    win_idx;
  logic [PRIO_W-1:0]                win_prio, top;
  logic [SW-1:0]                    depth;
  logic                             vec_rd, vec_wr;

  for (genvar s = 0; s < N_SRC; s++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cfg_q[s] <= '0;
      else if (wr_i && addr_i == ADDR_W'(s))  cfg_q[s] <= wdata_i;
    end
    assign en[s]      = cfg_q[s].en;
    assign edge_md[s] = cfg_q[s].edge_md;
    assign prio[s]    = cfg_q[s].prio;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spur_q <= '0;
      prot_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_SPUR) spur_q <= wdata_i[VEC_W-1:0];
      if (addr_i == A_CTRL) prot_q <= wdata_i[0];
    end
  end

  vic_src_front #(.N(N_SRC)) u_front (
    .clk_i, .rst_ni,
    .in_i      ({per_irq_i, ext_irq_i, fiq_src_i}),
    .edge_md_i (edge_md),
    .clr_i     (clr),
    .pend_o    (pend)
  );

  // source 0 is routed only to the fast output
  assign valid = pend & en & ~N_SRC'(1);

  vic_arbiter #(.N(N_SRC), .PW(PRIO_W)) u_arb (
    .clk_i, .rst_ni,
    .valid_i (valid),
    .prio_i  (prio),
    .any_o   (any),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  assign req    = any && (empty || win_prio > top);
  assign vec_rd = rd_i && addr_i == A_VEC;
  assign vec_wr = wr_i && addr_i == A_VEC;
  assign ack    = req && (prot_q ? vec_wr : vec_rd);
  assign pop    = wr_i && addr_i == A_EOI;
  assign clr    = (ack ? (N_SRC'(1) << win_idx) : '0)
                | N_SRC'(wr_i && addr_i == A_FCLR);

  vic_level_stack #(.DEPTH(LEVELS), .PW(PRIO_W)) u_stack (
    .clk_i, .rst_ni,
    .push_i  (ack),
    .lvl_i   (win_prio),
    .pop_i   (pop),
    .empty_o (empty),
    .top_o   (top),
    .depth_o (depth)
  );

  assign irq_no = ~req;
  assign fiq_no = ~(pend[0] & en[0]);

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SRC; s++)
      if (addr_i == ADDR_W'(s)) rdata_o = cfg_q[s];
    case (addr_i)
      A_VEC:   rdata_o = 32'(req ? cfg_q[win_idx].vec : spur_q);
      A_SPUR:  rdata_o = 32'(spur_q);
      A_CTRL:  rdata_o = 32'(prot_q);
      A_PEND:  rdata_o = 32'(pend);
      default: ;
    endcase
  end

  a_r9_protect_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && prot_q && !wr_i) |=> $stable(depth));
  a_r7_spur_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vec_rd || vec_wr) && !req && !pop) |=> $stable(depth));
  a_r2_fiq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_no |-> cfg_q[0].en);
endmodule

// File: tb/vic_ctrl_tb_top.sv
module vic_ctrl_tb_top;
  localparam int N_PER = 9;
  localparam int N_SRC = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fiq_src_i = 1'b0;
  logic [5:0] ext_irq_i = '0;
  logic [N_PER-1:0] per_irq_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_no, fiq_no;

  int checks = 0, errors = 0;
  int m_prio [N_SRC];
  bit m_en [N_SRC];

  always #4 clk_i = ~clk_i;

  vic_ctrl #(.N_PER(N_PER)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input bit side, output logic [31:0] d);
    @(negedge clk_i); rd_i = side; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic cfg(input int s, input logic [23:0] vec, input bit en,
                     input bit edg, input int p);
    m_prio[s] = p; m_en[s] = en;
    wr(6'(s), {vec, 3'b0, en, edg, 3'(p)});
  endtask

  task automatic set_src(input int s, input bit v);
    if (s == 0) fiq_src_i = v;
    else if (s <= 6) ext_irq_i[s-1] = v;
    else per_irq_i[s-7] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [N_SRC-1:0] raw_in();
    return {per_irq_i, ext_irq_i, fiq_src_i};
  endfunction

  function automatic int exp_win(input logic [N_SRC-1:0] p);
    int best = -1;
    for (int i = 1; i < N_SRC; i++)
      if (p[i] && m_en[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
    return best;
  endfunction

  initial begin
    repeat (20000 * 10) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w;
    void'($urandom(32'h1234));
    for (int i = 0; i < N_SRC; i++) begin m_prio[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(irq_no === 1'b1, "R1", irq_no, 1);
    chk(fiq_no === 1'b1, "R1", fiq_no, 1);
    rd(6'h22, 0, d); chk(d === 0, "R1", d, 0);
    rd(6'h24, 0, d); chk(d === 0, "R1", d, 0);
    rd(6'h03, 0, d); chk(d === 0, "R1", d, 0);
    wr(6'h22, 32'h00DEAD);

    // R2 fast line, level then edge
    cfg(0, 24'h0F0, 1, 0, 7);
    set_src(0, 1); settle();
    chk(fiq_no === 1'b0, "R2", fiq_no, 0);
    chk(irq_no === 1'b1, "R2", irq_no, 1);
    set_src(0, 0); settle();
    chk(fiq_no === 1'b1, "R2", fiq_no, 1);
    cfg(0, 24'h0F0, 1, 1, 7);
    set_src(0, 1); repeat (2) @(negedge clk_i); set_src(0, 0); settle();
    chk(fiq_no === 1'b0, "R2", fiq_no, 0);
    wr(6'h25, 0); @(negedge clk_i);
    chk(fiq_no === 1'b1, "R2", fiq_no, 1);
    cfg(0, 24'h0, 0, 0, 0);

    // R3 masked source
    cfg(5, 24'h105, 0, 0, 6);
    set_src(5, 1); settle();
    chk(irq_no === 1'b1, "R3", irq_no, 1);
    rd(6'h24, 0, d); chk(d[5] === 1'b1, "R10", d[5], 1);
    rd(6'h20, 1, d); chk(d === 32'h00DEAD, "R3", d, 32'h00DEAD);
    set_src(5, 0);

    // R4 tie: lowest index wins
    cfg(1, 24'h101, 1, 0, 4);
    cfg(6, 24'h106, 1, 0, 4);
    set_src(1, 1); set_src(6, 1); settle();
    chk(irq_no === 1'b0, "R5", irq_no, 0);
    rd(6'h20, 1, d); chk(d === 32'h101, "R4", d, 32'h101);
    wr(6'h21, 0);
    set_src(1, 0); set_src(6, 0); cfg(6, 24'h106, 0, 0, 0);

    // R5/R6 nesting
    cfg(1, 24'h101, 1, 0, 2);
    cfg(2, 24'h102, 1, 0, 5);
    set_src(1, 1); settle();
    rd(6'h20, 1, d); chk(d === 32'h101, "R6", d, 32'h101);
    chk(irq_no === 1'b1, "R5", irq_no, 1);
    set_src(2, 1); settle();
    chk(irq_no === 1'b0, "R5", irq_no, 0);
    rd(6'h20, 1, d); chk(d === 32'h102, "R6", d, 32'h102);
    chk(irq_no === 1'b1, "R5", irq_no, 1);
    rd(6'h20, 1, d); chk(d === 32'h00DEAD, "R7", d, 32'h00DEAD);
    wr(6'h21, 0);
    chk(irq_no === 1'b0, "R6", irq_no, 0);
    set_src(2, 0); settle();
    chk(irq_no === 1'b1, "R5", irq_no, 1);
    wr(6'h21, 0);
    chk(irq_no === 1'b0, "R6", irq_no, 0);
    set_src(1, 0); settle();
    chk(irq_no === 1'b1, "R6", irq_no, 1);
    wr(6'h21, 0); // empty stack: ignored
    set_src(1, 1); settle();
    rd(6'h20, 1, d); chk(d === 32'h101, "R6", d, 32'h101);
    wr(6'h21, 0); set_src(1, 0); settle();

    // R8 edge mode
    cfg(3, 24'h103, 1, 1, 1);
    set_src(3, 1); repeat (2) @(negedge clk_i); set_src(3, 0); settle();
    chk(irq_no === 1'b0, "R8", irq_no, 0);
    rd(6'h20, 1, d); chk(d === 32'h103, "R8", d, 32'h103);
    rd(6'h24, 0, d); chk(d[3] === 1'b0, "R8", d[3], 0);
    wr(6'h21, 0);
    chk(irq_no === 1'b1, "R8", irq_no, 1);

    // R9 protect mode
    wr(6'h23, 1);
    cfg(4, 24'h104, 1, 0, 3);
    set_src(4, 1); settle();
    rd(6'h20, 1, d); chk(d === 32'h104, "R9", d, 32'h104);
    chk(irq_no === 1'b0, "R9", irq_no, 0);
    rd(6'h20, 1, d); chk(d === 32'h104, "R9", d, 32'h104);
    wr(6'h20, 0);
    chk(irq_no === 1'b1, "R9", irq_no, 1);
    rd(6'h20, 1, d); chk(d === 32'h00DEAD, "R9", d, 32'h00DEAD);
    wr(6'h21, 0); wr(6'h23, 0);
    set_src(4, 0); settle();

    // R10 config readback
    rd(6'h04, 0, d); chk(d === {24'h104, 8'h13}, "R10", d, {24'h104, 8'h13});

    // random level-mode scenarios
    for (int it = 0; it < 150; it++) begin
      for (int s = 1; s < N_SRC; s++)
        cfg(s, 24'hA000 + 24'(s), 1'($urandom % 4 != 0), 0, int'($urandom % 8));
      ext_irq_i = 6'($urandom);
      per_irq_i = N_PER'($urandom);
      settle();
      w = exp_win(raw_in());
      rd(6'h24, 0, d);
      chk(d === 32'(raw_in()), "R10", d, 32'(raw_in()));
      chk(irq_no === (w < 0), "R5", irq_no, (w < 0));
      rd(6'h20, 1, d);
      if (w < 0) chk(d === 32'h00DEAD, "R7", d, 32'h00DEAD);
      else begin
        chk(d === 32'hA000 + 32'(w), "R4", d, 32'hA000 + 32'(w));
        wr(6'h21, 0);
      end
    end
    ext_irq_i = '0; per_irq_i = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule